// File: doc/BRIEF.md
# I2C Controller Command Word Sequencer

This block sits between a register write path and a bit-level I2C engine. Software writes 32-bit command words. Each word holds a data byte and a command code. The sequencer turns the stream of words into abstract bus requests: an address phase that returns an acknowledge, single-byte writes, a read of N bytes, and a STOP. It remembers whether a target is currently addressed and reports end-of-packet, STOP and NACK events as one-cycle pulses.

Transmit bytes are not sent when they are written. They collect in a small byte queue and go out as a burst of write requests as soon as a command of any other kind reaches the head of the command queue. Words that arrive while the engine is busy wait in a command FIFO, whose depth is a parameter. Flushing depends on a controller-enable level. An optional automatic-STOP mode closes a transfer when the receive side reports that it has been drained.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command word carries the data byte in bits 7:0 and the command code in bits 10:8. The codes are: 0 transmit, 1 receive, 2 STOP, 3 receive-and-discard, 4 START, 5 START expecting NACK, 6 high-speed START, 7 high-speed START expecting NACK. Bits 31:11 are ignored.
- R2: A transmit command with a target active only queues its byte. Any other command first sends every queued byte as a write request (op 1, byte in req_byte), oldest first, and then empties the queue.
- R3: Transmit, receive and receive-and-discard commands issued while no target is active produce no request and no event.
- R4: A receive command with a target active issues one read request (op 2) with req_byte equal to the byte count minus one. req_keep is 1 for code 1 and 0 for code 3.
- R5: START codes 4 and 6 issue an address request (op 0) whose req_byte is {0, data[7:1]}. req_hs is 1 for codes 6 and 7. An acknowledge makes the target active. A NACK pulses evt_nack and leaves no target active.
- R6: A START of any code issued while a target is active pulses evt_end_packet before its address request. For codes 4 and 6 with auto_stop high, a full STOP sequence (R8) runs before the address request.
- R7: START codes 5 and 7 pulse evt_nack when the address is acknowledged and not when it is refused. They leave the active state unchanged and never insert an automatic STOP.
- R8: A STOP command flushes the queue. It issues a STOP request (op 3) only if a target is active, deselects the target, and pulses evt_stop and evt_end_packet in the same cycle.
- R9: Queued bytes are sent only if ctrl_enable is high when the flush starts; otherwise they are discarded. A rising edge of ctrl_enable starts a flush of the queue.
- R10: A pulse on rx_drained while auto_stop is high causes a flush followed by a STOP sequence (R8).
- R11: Up to CMD_DEPTH words are held, including the one being executed. cmd_full is high when the FIFO is full, and a word written while it is full is dropped.
- R12: A transmit command that finds the byte queue full first flushes the queue, then queues its own byte.
- R13: A request holds req_valid and its fields stable until the cycle in which eng_done is high. eng_ack is sampled in that cycle.
- R14: After reset, req_valid, tgt_active, cmd_full and all event outputs are low. Each event is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Command word write strobe |
| wr_word | input | 32 | Command word |
| ctrl_enable | input | 1 | Controller enable level |
| auto_stop | input | 1 | Automatic STOP mode |
| rx_drained | input | 1 | Pulse: the receive FIFO was emptied by a read |
| cmd_full | output | 1 | Command FIFO full |
| req_valid | output | 1 | Bus request pending |
| req_op | output | 2 | 0 address, 1 write, 2 read, 3 STOP |
| req_byte | output | 8 | Address, write byte or read count minus one |
| req_hs | output | 1 | High-speed START |
| req_keep | output | 1 | Keep the read bytes |
| eng_done | input | 1 | Engine completes the pending request |
| eng_ack | input | 1 | Address was acknowledged (valid with eng_done) |
| tgt_active | output | 1 | A target is addressed |
| evt_end_packet | output | 1 | End-of-packet pulse |
| evt_stop | output | 1 | STOP pulse |
| evt_nack | output | 1 | NACK-detect pulse |

## Verification
A reference model predicts the ordered stream of requests and events, and every observed request or event is compared against it. The stimulus covers:
- commands with no target, which must produce nothing;
- short and queue-overflowing transmit runs, which separate queue-only behaviour from early flushing;
- receive against discard, which differ only in the keep flag;
- refused and acknowledged addresses for both START families, which separate the normal NACK rule from the inverted one;
- repeated starts with and without automatic STOP;
- a drained-receive STOP;
- transmits while disabled, followed by an enable edge, to tell discarding from deferred sending;
- a stalled engine with back-to-back writes, to show where command words start being dropped.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  // Command codes decoded from word bits 10:8 (R1)
  typedef enum logic [2:0] {
    CMD_TX       = 3'd0,
    CMD_RX       = 3'd1,
    CMD_STOP     = 3'd2,
    CMD_RX_DROP  = 3'd3,
    CMD_START    = 3'd4,
    CMD_START_N  = 3'd5,
    CMD_HSTART   = 3'd6,
    CMD_HSTART_N = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_STOP,
    ST_ADDR,
    ST_READ
  } state_e;

  typedef enum logic [1:0] {
    JOB_CMD,
    JOB_ENFL,
    JOB_ASTOP
  } job_e;

  localparam int WORD_USED = 11;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;
  assign dout    = mem_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_q == PW'(i))) mem_q[i] <= din;
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);
endmodule

// File: rtl/i2cq_decode.sv
module i2cq_decode
  import i2cq_pkg::*;
(
  input  logic [WORD_USED-1:0] word,
  output logic [7:0]           data,
  output logic                 is_tx,
  output logic                 is_rx,
  output logic                 is_start,
  output logic                 expect_nack,
  output logic                 hs,
  output logic                 keep
);
  cmd_e cmd;

  // R1: byte in 7:0, code in 10:8
  assign cmd         = cmd_e'(word[10:8]);
  assign data        = word[7:0];
  assign is_tx       = (cmd == CMD_TX);
  assign is_rx       = (cmd == CMD_RX) || (cmd == CMD_RX_DROP);
  assign keep        = (cmd == CMD_RX);
  assign is_start    = word[10];
  assign expect_nack = (cmd == CMD_START_N) || (cmd == CMD_HSTART_N);
  assign hs          = (cmd == CMD_HSTART) || (cmd == CMD_HSTART_N);
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
  import i2cq_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int TXQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_word,
  input  logic        ctrl_enable,
  input  logic        auto_stop,
  input  logic        rx_drained,
  output logic        cmd_full,
  output logic        req_valid,
  output logic [1:0]  req_op,
  output logic [7:0]  req_byte,
  output logic        req_hs,
  output logic        req_keep,
  input  logic        eng_done,
  input  logic        eng_ack,
  output logic        tgt_active,
  output logic        evt_end_packet,
  output logic        evt_stop,
  output logic        evt_nack
);
  state_e state_q, state_d;
  job_e   job_q, job_d;
  logic   active_q, active_d;
  logic   flen_q, flen_d;
  logic   asp_q, asp_d;
  logic   efp_q, efp_d;
  logic   en_q;
  logic   ep_q, ep_d, sd_q, sd_d, nd_q, nd_d;

  logic                 c_push, c_pop, c_empty, c_full;
  logic [WORD_USED-1:0] c_dout;
  logic                 b_push, b_pop, b_clr, b_empty, b_full;
  logic [7:0]           b_dout;

  logic [7:0] d_data;
  logic       d_is_tx, d_is_rx, d_is_start, d_expn, d_hs, d_keep;
  op_e        rop;
  logic       unused_hi;

  assign unused_hi = ^wr_word[31:WORD_USED];
  assign c_push    = wr_valid & ~c_full;

  i2cq_fifo #(.W(WORD_USED), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(c_push), .pop(c_pop), .clr(1'b0),
    .din(wr_word[WORD_USED-1:0]), .dout(c_dout), .empty(c_empty), .full(c_full)
  );

  i2cq_fifo #(.W(8), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(b_push), .pop(b_pop), .clr(b_clr),
    .din(d_data), .dout(b_dout), .empty(b_empty), .full(b_full)
  );

  i2cq_decode u_dec (
    .word(c_dout), .data(d_data), .is_tx(d_is_tx), .is_rx(d_is_rx),
    .is_start(d_is_start), .expect_nack(d_expn), .hs(d_hs), .keep(d_keep)
  );

  always_comb begin
    state_d   = state_q;
    job_d     = job_q;
    active_d  = active_q;
    flen_d    = flen_q;
    asp_d     = asp_q | (auto_stop & rx_drained);
    efp_d     = efp_q | (ctrl_enable & ~en_q);
    c_pop     = 1'b0;
    b_push    = 1'b0;
    b_pop     = 1'b0;
    b_clr     = 1'b0;
    ep_d      = 1'b0;
    sd_d      = 1'b0;
    nd_d      = 1'b0;
    req_valid = 1'b0;
    rop       = OP_WRITE;
    req_byte  = '0;
    req_hs    = 1'b0;
    req_keep  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (asp_q) begin
          asp_d   = auto_stop & rx_drained;
          job_d   = JOB_ASTOP;
          flen_d  = ctrl_enable;
          state_d = ST_FLUSH;
        end else if (efp_q) begin
          efp_d   = ctrl_enable & ~en_q;
          job_d   = JOB_ENFL;
          flen_d  = ctrl_enable;
          state_d = ST_FLUSH;
        end else if (!c_empty) begin
          if (d_is_tx && !active_q) begin
            c_pop = 1'b1;
          end else if (d_is_tx && !b_full) begin
            b_push = 1'b1;
            c_pop  = 1'b1;
          end else begin
            job_d   = JOB_CMD;
            flen_d  = ctrl_enable;
            state_d = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        if (!b_empty && flen_q) begin
          req_valid = 1'b1;
          rop       = OP_WRITE;
          req_byte  = b_dout;
          b_pop     = eng_done;
        end else begin
          b_clr = 1'b1;
          unique case (job_q)
            JOB_ENFL:  state_d = ST_IDLE;
            JOB_ASTOP: state_d = ST_STOP;
            default: begin
              if (d_is_tx) begin
                state_d = ST_IDLE;
              end else if (d_is_rx) begin
                c_pop   = ~active_q;
                state_d = active_q ? ST_READ : ST_IDLE;
              end else if (d_is_start) begin
                ep_d    = active_q;
                state_d = (auto_stop && !d_expn) ? ST_STOP : ST_ADDR;
              end else begin
                state_d = ST_STOP;
              end
            end
          endcase
        end
      end
      ST_STOP: begin
        req_valid = active_q;
        rop       = OP_STOP;
        if (!active_q || eng_done) begin
          active_d = 1'b0;
          sd_d     = 1'b1;
          ep_d     = 1'b1;
          if (job_q == JOB_CMD && d_is_start) begin
            state_d = ST_ADDR;
          end else begin
            c_pop   = (job_q == JOB_CMD);
            state_d = ST_IDLE;
          end
        end
      end
      ST_ADDR: begin
        req_valid = 1'b1;
        rop       = OP_ADDR;
        req_byte  = {1'b0, d_data[7:1]};
        req_hs    = d_hs;
        if (eng_done) begin
          if (d_expn) begin
            nd_d = eng_ack;
          end else begin
            active_d = eng_ack;
            nd_d     = ~eng_ack;
          end
          c_pop   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_READ: begin
        req_valid = 1'b1;
        rop       = OP_READ;
        req_byte  = d_data;
        req_keep  = d_keep;
        if (eng_done) begin
          c_pop   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      job_q    <= JOB_CMD;
      active_q <= 1'b0;
      flen_q   <= 1'b0;
      asp_q    <= 1'b0;
      efp_q    <= 1'b0;
      en_q     <= 1'b0;
      ep_q     <= 1'b0;
      sd_q     <= 1'b0;
      nd_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      job_q    <= job_d;
      active_q <= active_d;
      flen_q   <= flen_d;
      asp_q    <= asp_d;
      efp_q    <= efp_d;
      en_q     <= ctrl_enable;
      ep_q     <= ep_d;
      sd_q     <= sd_d;
      nd_q     <= nd_d;
    end
  end

  assign req_op         = rop;
  assign cmd_full       = c_full;
  assign tgt_active     = active_q;
  assign evt_end_packet = ep_q;
  assign evt_stop       = sd_q;
  assign evt_nack       = nd_q;

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !eng_done) |=> (req_valid && $stable(req_op) && $stable(req_byte)
                                  && $stable(req_hs) && $stable(req_keep)));
  a_r3_rw_needs_target: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_WRITE || req_op == OP_READ)) |-> tgt_active);
  a_r8_stop_pair: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |-> (evt_end_packet && !tgt_active));
  a_r14_nack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_nack |=> !evt_nack);
endmodule

// File: tb/i2c_cmd_sequencer_tb.sv
module i2c_cmd_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_DEPTH  = 4;
  localparam int TXQ_DEPTH  = 4;
  localparam int LAT        = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        ctrl_enable = 1'b0;
  logic        auto_stop = 1'b0;
  logic        rx_drained = 1'b0;
  logic        eng_done = 1'b0;
  logic        eng_ack = 1'b0;
  logic        cmd_full, req_valid, req_hs, req_keep, tgt_active;
  logic        evt_end_packet, evt_stop, evt_nack;
  logic [1:0]  req_op;
  logic [7:0]  req_byte;

  i2c_cmd_sequencer #(.CMD_DEPTH(CMD_DEPTH), .TXQ_DEPTH(TXQ_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .ctrl_enable(ctrl_enable), .auto_stop(auto_stop), .rx_drained(rx_drained),
    .cmd_full(cmd_full), .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte),
    .req_hs(req_hs), .req_keep(req_keep), .eng_done(eng_done), .eng_ack(eng_ack),
    .tgt_active(tgt_active), .evt_end_packet(evt_end_packet), .evt_stop(evt_stop),
    .evt_nack(evt_nack)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Observed/expected stream items: 0 request, 1 stop+end-packet, 2 end-packet, 3 nack, 9 lone stop
  typedef struct {
    int    kind;
    int    val;
    string req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  int    eng_cnt = 0;
  bit    stall = 1'b0;
  bit    running = 1'b0;
  bit    m_active = 1'b0;
  bit    m_en = 1'b0;
  bit    m_auto = 1'b0;
  int    m_txq[$];

  function automatic void expect_item(int kind, int val, string req);
    item_t it;
    it.kind = kind;
    it.val  = val;
    it.req  = req;
    exp_q.push_back(it);
  endfunction

  function automatic void check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endfunction

  function automatic void observe(int kind, int val);
    item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, "unexpected item", kind * 65536 + val, -1);
      return;
    end
    it = exp_q.pop_front();
    check(kind == it.kind && val == it.val, it.req, kind * 65536 + val, it.kind * 65536 + it.val);
  endfunction

  // Behavioural reference model
  function automatic void m_flush(string r);
    if (m_en) foreach (m_txq[i]) expect_item(0, 4096 + m_txq[i], r);
    m_txq.delete();
  endfunction

  function automatic void m_stop();
    if (m_active) expect_item(0, 3 * 4096, "R8 R13 stop request");
    m_active = 1'b0;
    expect_item(1, 0, "R8 stop events");
  endfunction

  function automatic void m_cmd(int w);
    int b = w & 255;
    int c = (w >> 8) & 7;
    int a = b >> 1;
    bit hs = (c == 6 || c == 7);
    bit ack = ((a & 64) == 0);
    if (c == 0) begin
      if (!m_active) return;
      if (m_txq.size() == TXQ_DEPTH) m_flush("R12 early flush");
      m_txq.push_back(b);
      return;
    end
    m_flush("R2 R9 flush");
    case (c)
      1, 3: if (m_active) expect_item(0, 2 * 4096 + ((c == 1) ? 1024 : 0) + b, "R4 read");
      2: m_stop();
      4, 6: begin
        if (m_active) expect_item(2, 0, "R6 repeated start");
        if (m_auto) m_stop();
        expect_item(0, (hs ? 2048 : 0) + a, "R5 address");
        m_active = ack;
        if (!ack) expect_item(3, 0, "R5 nack");
      end
      default: begin
        if (m_active) expect_item(2, 0, "R6 R7 repeated start");
        expect_item(0, (hs ? 2048 : 0) + a, "R7 address");
        if (ack) expect_item(3, 0, "R7 inverted nack");
      end
    endcase
  endfunction

  // Observer and engine model, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      if (evt_stop && evt_end_packet) observe(1, 0);
      else if (evt_stop) observe(9, 0);
      else if (evt_end_packet) observe(2, 0);
      if (evt_nack) observe(3, 0);
      if (eng_done) begin
        eng_done = 1'b0;
        eng_cnt  = 0;
      end else if (req_valid) begin
        eng_cnt++;
        if (eng_cnt >= LAT && !stall) begin
          eng_done = 1'b1;
          eng_ack  = (req_byte[6] == 1'b0);
          observe(0, int'(req_op) * 4096 + (req_hs ? 2048 : 0) + (req_keep ? 1024 : 0)
                     + int'(req_byte));
        end
      end
    end
  end

  task automatic send(int w);
    @(negedge clk);
    while (cmd_full) @(negedge clk);
    wr_word  = 32'(w);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    m_cmd(w);
  endtask

  task automatic raw_write(int w);
    wr_word  = 32'(w);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic settle();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ctrl_enable = 1'b1;
    m_en        = 1'b1;
    repeat (3) @(negedge clk);
    // R14: reset state
    check(req_valid == 0 && tgt_active == 0 && cmd_full == 0 && evt_stop == 0
          && evt_end_packet == 0 && evt_nack == 0, "R14 reset state",
          {req_valid, tgt_active, cmd_full, evt_stop, evt_end_packet, evt_nack}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (5) @(negedge clk);

    // R3: no target, R1 upper bits ignored
    send(32'hFFFF_F811);
    send('h102);
    send('h300);
    settle();
    check(tgt_active == 0, "R3 still idle", tgt_active, 0);

    // R5 address ack
    send('h420);
    settle();
    check(tgt_active == 1, "R5 active after ack", tgt_active, 1);

    // R2 queued bytes flushed by read; R4 keep and discard
    send('h0A1); send('h0A2); send('h0A3);
    send('h103);
    send('h300);
    settle();

    // R12 queue overflow, R8 stop
    for (int i = 0; i < 5; i++) send('h0B0 + i);
    send('h200);
    settle();
    check(tgt_active == 0, "R8 deselected", tgt_active, 0);

    // R5 refused address
    send('h4A0);
    send('h011);
    settle();
    check(tgt_active == 0, "R5 inactive after nack", tgt_active, 0);

    // R6 repeated start, plain and with auto stop; high-speed flag
    send('h420);
    send('h662);
    settle();
    auto_stop = 1'b1; m_auto = 1'b1;
    send('h420);
    settle();
    auto_stop = 1'b0; m_auto = 1'b0;

    // R7 inverted NACK rule
    send('h520);
    send('h7A0);
    settle();
    check(tgt_active == 1, "R7 active unchanged", tgt_active, 1);

    // R10 drained receive with auto stop
    auto_stop = 1'b1; m_auto = 1'b1;
    send('h055);
    settle();
    rx_drained = 1'b1;
    @(negedge clk);
    rx_drained = 1'b0;
    m_flush("R10 flush");
    m_stop();
    settle();
    auto_stop = 1'b0; m_auto = 1'b0;

    // R9 disabled flush discards, enable edge flushes
    ctrl_enable = 1'b0; m_en = 1'b0;
    send('h420); send('h066); send('h200);
    settle();
    send('h420); send('h077);
    settle();
    ctrl_enable = 1'b1; m_en = 1'b1;
    m_flush("R9 enable edge flush");
    settle();
    send('h200);
    settle();

    // R11 command FIFO full with a stalled engine
    send('h420);
    settle();
    stall = 1'b1;
    send('h200);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) raw_write('h5A0);
    for (int i = 0; i < CMD_DEPTH - 1; i++) m_cmd('h5A0);
    check(cmd_full == 1, "R11 full after burst", cmd_full, 1);
    stall = 1'b0;
    settle();
    check(cmd_full == 0, "R11 drained", cmd_full, 0);

    settle();
    check(exp_q.size() == 0, "all items seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule